// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes. The host hands it one byte-wide read or write at a time through a request/ready handshake. The controller then produces the chip-select, write-enable and output-enable sequence that the memory needs. Every interval is a whole number of clock cycles, derived from nanosecond limits and a clock-period parameter. Read data comes back with a single-cycle valid pulse.

The memory data bus is split into an output byte, an output-enable and an input byte, so that a tri-state pad outside the block can join them. The bus is driven only during the data part of a write. Chip select and write enable fall together with output enable held high, so the memory never turns its own drivers on during a write. A release window at the start of each write gives the memory time to release the bus after a preceding read.

Each phase length is the ceiling of its nanosecond limit divided by the clock period, and never less than one cycle. With the default 5 ns clock this gives:

| Quantity | Cycles |
|---|---|
| Read access | 14 |
| Write release window | 5 |
| Write data window | 7 |
| Minimum request spacing | 14 |

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held, and once it has been released with no request, host_ready is 1, mem_cs_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe and host_rvalid are 0.
- R2: A read that is accepted (host_req and host_ready high at a clock edge with host_wr low) holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1. This lasts exactly N_ACC cycles after the accepting edge, with N_ACC = max(ceil(70/T), ceil(35/T)), which is 14 at T=5 ns. All three strobes are then 1 again.
- R3: The read byte is sampled from mem_dq_in on the last access cycle. It is presented on host_rdata with host_rvalid=1 for exactly one cycle, the cycle right after the access phase.
- R4: In an accepted write, mem_cs_n and mem_we_n fall in the same cycle and rise in the same cycle, and mem_oe_n stays 1 throughout.
- R5: The first N_REL = ceil(25/T) cycles of a write strobe (5 at T=5 ns) leave mem_dq_oe at 0.
- R6: After the release window, mem_dq_oe=1 and mem_dq_out carries the accepted write byte for N_DAT cycles while both strobes stay low. N_DAT = max(ceil(30/T), max(ceil(50/T), ceil(60/T)) - N_REL), at least 1, which is 7 at T=5 ns. The whole strobe is therefore 12 cycles.
- R7: In the cycle where the write strobes rise, mem_dq_oe is still 1 with the same byte. In the next cycle it is 0.
- R8: mem_addr equals the accepted host_addr for the whole strobe phase, even if the host changes its inputs after acceptance.
- R9: host_ready goes to 0 in the cycle after acceptance. It returns to 1 after k cycles, where k = max(sequence length, N_CYC-1) and N_CYC = ceil(70/T). This makes k 14 for a read and 13 for a write at T=5 ns, so accepted requests are at least N_CYC cycles apart.
- R10: mem_dq_oe is never 1 while mem_cs_n=0 and mem_oe_n=0, and mem_oe_n is 0 only while mem_cs_n=0 and mem_we_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Request strobe, taken when host_ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Controller can accept a request this cycle |
| host_rvalid | output | 1 | One-cycle pulse: host_rdata holds read data |
| host_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte to drive onto the memory bus |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte read from the memory bus |

## Verification
The bench runs reads of locations never written, which return a computed default pattern, and reads of locations it has written. This separates a broken read path from a broken write path. Writes of 00, FF, 5A and A5 go to the lowest, highest and a middle address, and would expose stuck or swapped data and address bits. Back-to-back requests with the request held high test the cycle-time spacing and the turnaround from a read to a write. Requests after idle gaps test the path from idle. Two writes to one address followed by a read show that the later byte is the one committed. Changing the host inputs right after acceptance shows that the address and data are held.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_RD_ACC = 3'd1,
    SEQ_WR_REL = 3'd2,
    SEQ_WR_DAT = 3'd3,
    SEQ_WR_END = 3'd4
  } seq_state_e;

  // Whole cycles covering a nanosecond limit, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
#(
  parameter int N_ACC = 14,
  parameter int N_REL = 5,
  parameter int N_DAT = 7,
  parameter int PH_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            accept_wr,
  input  logic            phase_done,
  output seq_state_e      state_q,
  output seq_state_e      state_d,
  output logic            ph_load,
  output logic [PH_W-1:0] ph_val,
  output logic            rd_capture
);

  always_comb begin
    state_d    = state_q;
    ph_load    = 1'b0;
    ph_val     = '0;
    rd_capture = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          ph_load = 1'b1;
          if (accept_wr) begin
            state_d = SEQ_WR_REL;
            ph_val  = PH_W'(N_REL - 1);
          end else begin
            state_d = SEQ_RD_ACC;
            ph_val  = PH_W'(N_ACC - 1);
          end
        end
      end
      SEQ_RD_ACC: begin
        if (phase_done) begin
          rd_capture = 1'b1;
          state_d    = SEQ_IDLE;
        end
      end
      SEQ_WR_REL: begin
        if (phase_done) begin
          state_d = SEQ_WR_DAT;
          ph_load = 1'b1;
          ph_val  = PH_W'(N_DAT - 1);
        end
      end
      SEQ_WR_DAT: begin
        if (phase_done) state_d = SEQ_WR_END;
      end
      SEQ_WR_END: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  seq_state_e        state_d,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid
);

  logic cs_act, we_act, oe_act, drv_act;

  // Pin levels for the state being entered, so every pin leaves a flop.
  always_comb begin
    cs_act  = (state_d == SEQ_RD_ACC) || (state_d == SEQ_WR_REL) || (state_d == SEQ_WR_DAT);
    we_act  = (state_d == SEQ_WR_REL) || (state_d == SEQ_WR_DAT);
    oe_act  = (state_d == SEQ_RD_ACC);
    drv_act = (state_d == SEQ_WR_DAT) || (state_d == SEQ_WR_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs_n  <= ~cs_act;
      mem_we_n  <= ~we_act;
      mem_oe_n  <= ~oe_act;
      mem_dq_oe <= drv_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= host_addr;
      mem_dq_out <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          host_rdata <= '0;
    else if (rd_capture) host_rdata <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= rd_capture;
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ADDR_ACC_NS = 70,
  parameter int T_OE_ACC_NS   = 35,
  parameter int T_WP_NS       = 50,
  parameter int T_AW_NS       = 60,
  parameter int T_DS_NS       = 30,
  parameter int T_CYC_NS      = 70,
  parameter int T_RELEASE_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int N_ACC  = imax(ns_to_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                               ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS));
  localparam int N_REL  = ns_to_cycles(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int N_STRB = imax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                               ns_to_cycles(T_AW_NS, CLK_PERIOD_NS));
  localparam int N_DAT  = imax(imax(ns_to_cycles(T_DS_NS, CLK_PERIOD_NS), N_STRB - N_REL), 1);
  localparam int N_CYC  = ns_to_cycles(T_CYC_NS, CLK_PERIOD_NS);
  localparam int PH_MAX = imax(imax(N_ACC, N_REL), N_DAT);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int CYC_W  = $clog2(N_CYC + 1);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e      state_q;
  seq_state_e      state_d;
  logic            ph_load;
  logic [PH_W-1:0] ph_val;
  logic            ph_done;
  logic            rd_capture;
  logic            cyc_done;
  logic            accept;

  assign host_ready = (state_q == SEQ_IDLE) && cyc_done;
  assign accept     = host_req && host_ready;

  sram_seq_fsm #(
    .N_ACC (N_ACC),
    .N_REL (N_REL),
    .N_DAT (N_DAT),
    .PH_W  (PH_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .accept_wr  (host_wr),
    .phase_done (ph_done),
    .state_q    (state_q),
    .state_d    (state_d),
    .ph_load    (ph_load),
    .ph_val     (ph_val),
    .rd_capture (rd_capture)
  );

  sram_phase_timer #(.CNT_W(PH_W)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ph_load),
    .load_val (ph_val),
    .expired  (ph_done)
  );

  sram_phase_timer #(.CNT_W(CYC_W)) u_cyc_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (accept),
    .load_val (CYC_W'(N_CYC - 1)),
    .expired  (cyc_done)
  );

  sram_pin_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .accept      (accept),
    .state_d     (state_d),
    .rd_capture  (rd_capture),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .mem_dq_in   (mem_dq_in),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_req,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  assert_read_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);

  assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  assert_end_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs_n) && $past(!mem_we_n)) |-> mem_dq_oe);

  assert_end_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs_n) && $past(!mem_we_n)) |=> !mem_dq_oe);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready) |=> !host_ready);

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_req    (host_req),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .mem_addr    (mem_addr),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_dq_oe   (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/100ps
module sram_strobe_ctrl_tb;

  localparam int PER = 5;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int NACC   = mx(cyc_of(70), cyc_of(35));
  localparam int NREL   = cyc_of(25);
  localparam int NDAT   = mx(mx(cyc_of(30), mx(cyc_of(50), cyc_of(60)) - NREL), 1);
  localparam int NCYC   = cyc_of(70);
  localparam int RD_RDY = mx(NACC, NCYC - 1);
  localparam int WR_RDY = mx(NREL + NDAT + 1, NCYC - 1);

  logic        clk;
  logic        rst_n = 1'b0;
  logic        host_req, host_wr;
  logic [18:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_ready, host_rvalid;
  logic [7:0]  host_rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;
  logic [7:0]  rd_byte;

  sram_strobe_ctrl #(.CLK_PERIOD_NS(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_byte : 8'h00;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // Reference model state
  bit          mon_en = 0, busy = 0, op_wr = 0, acc_seen = 0, prev_ws = 0;
  int          k = 0;
  logic [18:0] op_a, nxt_a;
  logic [7:0]  op_d, nxt_d;
  bit          nxt_wr;
  logic [7:0]  shadow [int];
  logic [7:0]  mem    [int];
  logic [7:0]  exp_q  [$];

  always @(negedge clk) begin : ref_model
    logic  ecs, ewe, eoe, edrv, erdy, ervl, ws;
    logic [7:0] ebyte;
    string tg;
    if (mon_en) begin
      if (acc_seen) begin
        busy = 1; k = 0; op_wr = nxt_wr; op_a = nxt_a; op_d = nxt_d;
      end else if (busy) k++;
      ecs = 1; ewe = 1; eoe = 1; edrv = 0; erdy = 1; ervl = 0; tg = "R1";
      if (busy) begin
        if (!op_wr) begin
          if (k < NACC) begin ecs = 0; eoe = 0; tg = "R2"; end
          ervl = (k == NACC);
          erdy = (k >= RD_RDY);
        end else begin
          if (k < NREL) begin ecs = 0; ewe = 0; tg = "R5"; end
          else if (k < NREL + NDAT) begin ecs = 0; ewe = 0; edrv = 1; tg = "R6"; end
          else if (k == NREL + NDAT) begin edrv = 1; tg = "R7"; end
          else tg = "R4";
          erdy = (k >= WR_RDY);
        end
      end
      cmp({tg, " cs_n"}, mem_cs_n, ecs);
      cmp({tg, " we_n"}, mem_we_n, ewe);
      cmp({tg, " oe_n"}, mem_oe_n, eoe);
      cmp({tg, " dq_oe"}, mem_dq_oe, edrv);
      cmp("R9 ready", host_ready, erdy);
      cmp("R3 rvalid", host_rvalid, ervl);
      if (ervl) begin
        ebyte = exp_q.pop_front();
        cmp("R3 rdata", host_rdata, ebyte);
      end
      if (busy && !ecs) cmp("R8 addr", mem_addr, op_a);
      if (edrv) cmp("R6 dq_out", mem_dq_out, op_d);
      cmp("R10 contention", mem_dq_oe && !mem_cs_n && !mem_oe_n, 0);
      ws = !mem_cs_n && !mem_we_n;
      if (prev_ws && !ws) begin
        cmp("R7 driven at strobe rise", mem_dq_oe, 1);
        mem[int'(mem_addr)] = mem_dq_out;
      end
      prev_ws = ws;
      rd_byte = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : dflt(mem_addr);
      acc_seen = host_req && host_ready;
      if (acc_seen) begin
        nxt_wr = host_wr; nxt_a = host_addr; nxt_d = host_wdata;
        if (host_wr) shadow[int'(host_addr)] = host_wdata;
        else exp_q.push_back(shadow.exists(int'(host_addr)) ? shadow[int'(host_addr)]
                                                           : dflt(host_addr));
      end
    end
  end

  task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    do @(posedge clk); while (!acc_seen);
    #1;
    host_req = 1'b0; host_wr = ~wr; host_addr = ~a; host_wdata = ~d;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    host_req = 0; host_wr = 0; host_addr = '0; host_wdata = '0; rd_byte = '0;
    repeat (3) @(negedge clk);
    cmp("R1 ready in reset", host_ready, 1);
    cmp("R1 cs_n in reset", mem_cs_n, 1);
    cmp("R1 we_n in reset", mem_we_n, 1);
    cmp("R1 oe_n in reset", mem_oe_n, 1);
    cmp("R1 dq_oe in reset", mem_dq_oe, 0);
    cmp("R1 rvalid in reset", host_rvalid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    cmp("R1 ready after reset", host_ready, 1);
    cmp("R1 strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    mon_en = 1;
    @(posedge clk); #1;

    do_op(0, 19'h00123, 8'h00);          // unwritten location, R2/R3
    do_op(1, 19'h00000, 8'h5A);          // read-to-write turnaround, R5/R6
    do_op(1, 19'h7FFFF, 8'hA5);
    do_op(0, 19'h00000, 8'h00);
    do_op(0, 19'h7FFFF, 8'h00);
    do_op(1, 19'h2A55A, 8'hFF);
    do_op(1, 19'h2A55A, 8'h00);          // overwrite, later byte must win
    do_op(0, 19'h2A55A, 8'h00);
    repeat (7) @(posedge clk); #1;       // idle gap
    do_op(1, 19'h00001, 8'h3C);
    repeat (3) @(posedge clk); #1;
    do_op(0, 19'h00001, 8'h00);
    do_op(0, 19'h00000, 8'h00);
    repeat (25) @(posedge clk); #1;
    cmp("R3 all reads returned", exp_q.size(), 0);
    finish_run();
  end

endmodule